// File: doc/BRIEF.md
# Indexed Effective-Address Generator

This block turns a decoded 36-bit instruction word into a 15-bit effective address. It subtracts an index quantity from the word's address field. The index quantity comes from a bank of seven 15-bit index registers, and a 3-bit selector field in the word picks which registers take part. The same block also carries out index-register loads, a one-way mode switch and one level of indirect addressing.

The block has two selector modes. After reset it is in a legacy mode, where only registers 1, 2 and 4 take part. Each selector bit stands for one of those registers, and when several bits are set their contents are ORed together, both for reads and for loads. A dedicated leave command moves the block into a direct mode, where the selector value is a register number from 1 to 7. Only a reset brings the legacy mode back.

When an instruction asks for indirection, the block raises a request and waits. The surrounding datapath fetches the indirect word and hands it back on a dedicated input. That word's selector and address field are then indexed in the same way.

Top module: `ixaddr_unit`

## Requirements
- R1: The input word is a vector [35:0]. The address field Y is bits [14:0]. The selector is bits [17:15], with bit 15 as its least significant bit. The indirection flag is bits [23:22]. All other bits are ignored. A selector of 0 gives an address equal to Y.
- R2: While reset is high and after it drops, ea_valid and need_indirect are 0, the block is in legacy mode, and all seven index registers hold 0.
- R3: In legacy mode the index quantity is the bitwise OR of the registers picked by the selector bits. Selector bit 0 picks register 1, bit 1 picks register 2 and bit 2 picks register 4.
- R4: A pulse on xr_load writes load_value. The target registers are chosen by the selector field of instr_word in that same cycle. In legacy mode every register picked under R3 receives the same value, and the other registers keep their contents.
- R5: In direct mode a selector value n from 1 to 7 reads register n as the index quantity, and a load writes register n only.
- R6: leave_compat switches the block to direct mode, and only reset switches it back. A load in the same cycle as leave_compat already uses direct mode. A load in the same cycle as reset is applied after the clearing, using legacy mode.
- R7: When is_xctl is high with an accepted instruction, the address is Y unchanged. Such an instruction never asks for indirection, whatever its flag.
- R8: An accepted instruction with flag 2'b11 and is_xctl low raises need_indirect on the next cycle and produces no address. need_indirect stays high until ind_valid is seen. On the cycle after that, ea_valid is high and the address is computed from ind_word's selector and Y, with ind_word's own flag ignored.
- R9: ea_valid is a one-cycle pulse, registered one cycle after the accepted instruction or indirect word. The address uses the mode and register contents from before that clock edge, so a load or leave in the same cycle does not affect it.
- R10: instr_valid is ignored while need_indirect is high, and ind_valid is ignored while need_indirect is low.
- R11: The subtraction wraps modulo 2^15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr_word | input | 36 | Decoded instruction word; its selector also steers loads |
| is_xctl | input | 1 | Instruction is an index-control type (no indexing) |
| xr_load | input | 1 | Write load_value into the selected index registers |
| load_value | input | 15 | Value for index-register loads |
| leave_compat | input | 1 | Leave legacy mode for direct mode |
| ind_valid | input | 1 | Indirect word present this cycle |
| ind_word | input | 36 | Fetched indirect word |
| ea_valid | output | 1 | Effective address valid pulse |
| ea | output | 15 | Effective address |
| need_indirect | output | 1 | Waiting for an indirect word |

## Verification
Index registers and the mode bit can only be seen through later addresses. A wrong register write or an early mode change therefore shows up only when a later instruction selects that register. The bench reads every register back with single-bit and multi-bit selectors, in both modes, right after each load. A stuck or mistimed wait state shows within one cycle: ea_valid and need_indirect are compared on the very next cycle after each request and each indirect word.

// File: rtl/ixaddr_pkg.sv
package ixaddr_pkg;
  localparam int IXA_WORD_W   = 36;
  localparam int IXA_ADDR_W   = 15;
  localparam int IXA_TAG_W    = 3;
  // flag sits two bits wide; its low bit in vector numbering
  localparam int IXA_FLAG_LSB = 22;
  localparam logic [1:0] IXA_FLAG_IND = 2'b11;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ixa_state_e;
endpackage

// File: rtl/ixaddr_decode.sv
module ixaddr_decode #(
  parameter int WORD_W   = 36,
  parameter int ADDR_W   = 15,
  parameter int TAG_W    = 3,
  parameter int FLAG_LSB = 22
) (
  input  logic [WORD_W-1:0] word,
  output logic [1:0]        flag,
  output logic [TAG_W-1:0]  tag,
  output logic [ADDR_W-1:0] y
);
  localparam int TAG_LSB = ADDR_W;
  localparam int GAP_LSB = TAG_LSB + TAG_W;

  logic unused_fields;

  assign y    = word[ADDR_W-1:0];
  assign tag  = word[TAG_LSB +: TAG_W];
  assign flag = word[FLAG_LSB +: 2];

  assign unused_fields = ^{word[WORD_W-1:FLAG_LSB+2], word[FLAG_LSB-1:GAP_LSB]};
endmodule

// File: rtl/ixaddr_xrfile.sv
module ixaddr_xrfile #(
  parameter int ADDR_W = 15,
  parameter int TAG_W  = 3,
  parameter int NUM_XR = 7
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         wr_compat,
  input  logic [TAG_W-1:0]             wr_tag,
  input  logic [ADDR_W-1:0]            wr_val,
  output logic [(NUM_XR+1)*ADDR_W-1:0] xr_flat
);
  // slot 0 is the constant zero seen by selector value 0
  assign xr_flat[ADDR_W-1:0] = '0;

  for (genvar i = 1; i <= NUM_XR; i++) begin : g_xr
    localparam bit IS_POW2 = ((i & (i - 1)) == 0);
    logic              hit;
    logic [ADDR_W-1:0] q;

    if (IS_POW2) begin : g_legacy
      localparam int SEL_BIT = $clog2(i);
      assign hit = wr_compat ? wr_tag[SEL_BIT] : (wr_tag == TAG_W'(i));
    end else begin : g_direct_only
      assign hit = !wr_compat && (wr_tag == TAG_W'(i));
    end

    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      if (wr_en && hit) q <= wr_val;
    end

    assign xr_flat[i*ADDR_W +: ADDR_W] = q;
  end
endmodule

// File: rtl/ixaddr_xrsel.sv
module ixaddr_xrsel #(
  parameter int ADDR_W = 15,
  parameter int TAG_W  = 3,
  parameter int NUM_XR = 7
) (
  input  logic                         compat,
  input  logic [TAG_W-1:0]             tag,
  input  logic [(NUM_XR+1)*ADDR_W-1:0] xr_flat,
  output logic [ADDR_W-1:0]            ct
);
  logic [TAG_W:0][ADDR_W-1:0] or_chain;
  logic [ADDR_W-1:0]          direct;

  assign or_chain[0] = '0;
  for (genvar b = 0; b < TAG_W; b++) begin : g_or
    assign or_chain[b+1] = or_chain[b] |
                           (tag[b] ? xr_flat[(1 << b)*ADDR_W +: ADDR_W] : '0);
  end

  always_comb begin
    direct = '0;
    for (int n = 0; n <= NUM_XR; n++) begin
      if (tag == TAG_W'(n)) direct = xr_flat[n*ADDR_W +: ADDR_W];
    end
  end

  assign ct = compat ? or_chain[TAG_W] : direct;
endmodule

// File: rtl/ixaddr_unit.sv
module ixaddr_unit
  import ixaddr_pkg::*;
#(
  parameter int WORD_W   = IXA_WORD_W,
  parameter int ADDR_W   = IXA_ADDR_W,
  parameter int TAG_W    = IXA_TAG_W,
  parameter int FLAG_LSB = IXA_FLAG_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [WORD_W-1:0] instr_word,
  input  logic              is_xctl,
  input  logic              xr_load,
  input  logic [ADDR_W-1:0] load_value,
  input  logic              leave_compat,
  input  logic              ind_valid,
  input  logic [WORD_W-1:0] ind_word,
  output logic              ea_valid,
  output logic [ADDR_W-1:0] ea,
  output logic              need_indirect
);
  localparam int NUM_XR = (1 << TAG_W) - 1;
  localparam int FLAT_W = (NUM_XR + 1) * ADDR_W;

  ixa_state_e        st_q;
  logic              mode_q;
  logic              wr_compat;
  logic [WORD_W-1:0] word_sel;
  logic [1:0]        dec_flag;
  logic [TAG_W-1:0]  dec_tag;
  logic [ADDR_W-1:0] dec_y;
  logic [FLAT_W-1:0] xr_flat;
  logic [ADDR_W-1:0] ct;
  logic [ADDR_W-1:0] ea_sum;
  logic [ADDR_W-1:0] ea_next;
  logic              take_instr;
  logic              take_ind;
  logic              go_indirect;
  logic              emit;

  // while waiting, the indirect word drives the decoder
  assign word_sel = (st_q == ST_WAIT) ? ind_word : instr_word;

  ixaddr_decode #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .FLAG_LSB(FLAG_LSB)
  ) u_decode (
    .word(word_sel), .flag(dec_flag), .tag(dec_tag), .y(dec_y)
  );

  ixaddr_xrsel #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .NUM_XR(NUM_XR)
  ) u_xrsel (
    .compat(mode_q), .tag(dec_tag), .xr_flat(xr_flat), .ct(ct)
  );

  // mode seen by a load: reset and leave take effect first
  assign wr_compat = rst | (mode_q & ~leave_compat);

  ixaddr_xrfile #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .NUM_XR(NUM_XR)
  ) u_xrfile (
    .clk(clk), .rst(rst), .wr_en(xr_load), .wr_compat(wr_compat),
    .wr_tag(instr_word[ADDR_W +: TAG_W]), .wr_val(load_value),
    .xr_flat(xr_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b1;
    else if (leave_compat) mode_q <= 1'b0;
  end

  assign take_instr  = instr_valid && (st_q == ST_IDLE);
  assign take_ind    = ind_valid && (st_q == ST_WAIT);
  assign go_indirect = take_instr && !is_xctl && (dec_flag == IXA_FLAG_IND);
  assign emit        = (take_instr && !go_indirect) || take_ind;

  assign ea_sum  = dec_y - ct;
  assign ea_next = ((st_q == ST_IDLE) && is_xctl) ? dec_y : ea_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      ea_valid <= 1'b0;
      ea       <= '0;
    end else begin
      ea_valid <= emit;
      if (emit) ea <= ea_next;
      if (go_indirect) st_q <= ST_WAIT;
      else if (take_ind) st_q <= ST_IDLE;
    end
  end

  assign need_indirect = (st_q == ST_WAIT);
endmodule

// File: rtl/ixaddr_unit_chk.sv
module ixaddr_unit_chk #(
  parameter int ADDR_W = 15,
  parameter int TAG_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_valid,
  input logic              is_xctl,
  input logic              leave_compat,
  input logic              ind_valid,
  input logic              ea_valid,
  input logic [ADDR_W-1:0] ea,
  input logic              need_indirect,
  input logic              mode_q,
  input logic [1:0]        dec_flag,
  input logic [TAG_W-1:0]  dec_tag,
  input logic [ADDR_W-1:0] dec_y
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> mode_q && !ea_valid && !need_indirect); // R2
  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (rst)
    !mode_q |=> !mode_q); // R6
  AST_LEAVE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    leave_compat |=> !mode_q); // R6
  AST_XCTL_PASS: assert property (@(posedge clk) disable iff (rst)
    instr_valid && !need_indirect && is_xctl |=> ea_valid && ea == $past(dec_y)); // R7
  AST_TAG0_PASS: assert property (@(posedge clk) disable iff (rst)
    instr_valid && !need_indirect && !is_xctl && dec_flag != 2'b11 && dec_tag == '0
    |=> ea_valid && ea == $past(dec_y)); // R1
  AST_IND_REQUEST: assert property (@(posedge clk) disable iff (rst)
    instr_valid && !need_indirect && !is_xctl && dec_flag == 2'b11
    |=> need_indirect && !ea_valid); // R8
  AST_IND_DONE: assert property (@(posedge clk) disable iff (rst)
    need_indirect && ind_valid |=> ea_valid && !need_indirect); // R8
  AST_IND_HOLD: assert property (@(posedge clk) disable iff (rst)
    need_indirect && !ind_valid |=> need_indirect && !ea_valid); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !need_indirect && !instr_valid |=> !ea_valid); // R10
  AST_NO_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(ea_valid && need_indirect)); // R9
endmodule

bind ixaddr_unit ixaddr_unit_chk #(
  .ADDR_W(ADDR_W), .TAG_W(TAG_W)
) u_chk (
  .clk(clk), .rst(rst), .instr_valid(instr_valid), .is_xctl(is_xctl),
  .leave_compat(leave_compat), .ind_valid(ind_valid), .ea_valid(ea_valid),
  .ea(ea), .need_indirect(need_indirect), .mode_q(mode_q),
  .dec_flag(dec_flag), .dec_tag(dec_tag), .dec_y(dec_y)
);

// File: tb/ixaddr_unit_tb.sv
module ixaddr_unit_tb;
  localparam int WW = 36;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          instr_valid = 1'b0;
  logic [WW-1:0] instr_word = '0;
  logic          is_xctl = 1'b0;
  logic          xr_load = 1'b0;
  logic [AW-1:0] load_value = '0;
  logic          leave_compat = 1'b0;
  logic          ind_valid = 1'b0;
  logic [WW-1:0] ind_word = '0;
  logic          ea_valid;
  logic [AW-1:0] ea;
  logic          need_indirect;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [AW-1:0] m_xr [8];
  bit            m_compat;

  always #5 clk = ~clk;

  ixaddr_unit u_dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .is_xctl(is_xctl), .xr_load(xr_load), .load_value(load_value),
    .leave_compat(leave_compat), .ind_valid(ind_valid), .ind_word(ind_word),
    .ea_valid(ea_valid), .ea(ea), .need_indirect(need_indirect)
  );

  function automatic logic [WW-1:0] mk(input logic [1:0] f, input logic [2:0] t,
                                       input logic [AW-1:0] y);
    return {12'hA5C, f, 4'b1001, t, y};
  endfunction

  function automatic logic [AW-1:0] exp_ea(input logic [2:0] t, input logic [AW-1:0] y);
    logic [AW-1:0] c;
    c = '0;
    if (m_compat) begin
      if (t[0]) c = c | m_xr[1];
      if (t[1]) c = c | m_xr[2];
      if (t[2]) c = c | m_xr[4];
    end else c = m_xr[t];
    return y - c;
  endfunction

  function automatic void model_load(input logic [2:0] t, input logic [AW-1:0] v);
    if (m_compat) begin
      if (t[0]) m_xr[1] = v;
      if (t[1]) m_xr[2] = v;
      if (t[2]) m_xr[4] = v;
    end else if (t != 0) m_xr[t] = v;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [WW-1:0] w, input logic xc);
    @(negedge clk);
    instr_word = w; is_xctl = xc; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0; is_xctl = 1'b0;
  endtask

  task automatic load(input logic [2:0] t, input logic [AW-1:0] v, input bit lv);
    @(negedge clk);
    instr_word = mk(2'b00, t, '0); load_value = v; xr_load = 1'b1; leave_compat = lv;
    if (lv) m_compat = 1'b0;
    model_load(t, v);
    @(negedge clk);
    xr_load = 1'b0; leave_compat = 1'b0;
  endtask

  task automatic ea_is(input string req, input logic [2:0] t, input logic [AW-1:0] y);
    logic [AW-1:0] e;
    e = exp_ea(t, y);
    issue(mk(2'b00, t, y), 1'b0);
    chk(req, "ea_valid", 32'(ea_valid), 32'd1);
    chk(req, "ea", 32'(ea), 32'(e));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R2", "ea_valid in reset", 32'(ea_valid), 32'd0);
    chk("R2", "need_indirect in reset", 32'(need_indirect), 32'd0);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) m_xr[i] = '0;
    m_compat = 1'b1;
    ea_is("R2", 3'd7, 15'd100);
    chk("R2", "ea all-zero regs", 32'(ea), 32'd100);
  endtask

  task automatic t_compat();
    load(3'd3, 15'h0011, 1'b0);
    load(3'd4, 15'h0100, 1'b0);
    ea_is("R3", 3'd7, 15'h1000);
    chk("R3", "ea tag7 or", 32'(ea), 32'h0EEF);
    ea_is("R4", 3'd2, 15'h0050);
    chk("R4", "ea tag2 multi-load", 32'(ea), 32'h003F);
    ea_is("R11", 3'd1, 15'h0005);
    chk("R11", "ea wrap", 32'(ea), 32'h7FF4);
    @(negedge clk);
    chk("R9", "ea_valid single pulse", 32'(ea_valid), 32'd0);
    ea_is("R1", 3'd0, 15'h2222);
  endtask

  task automatic t_xctl();
    issue(mk(2'b11, 3'd7, 15'h1234), 1'b1);
    chk("R7", "ea_valid", 32'(ea_valid), 32'd1);
    chk("R7", "ea raw Y", 32'(ea), 32'h1234);
    chk("R7", "no indirect", 32'(need_indirect), 32'd0);
  endtask

  task automatic t_indirect(input logic [2:0] t, input logic [AW-1:0] y);
    logic [AW-1:0] e;
    issue(mk(2'b11, 3'd0, 15'h7777), 1'b0);
    chk("R8", "need_indirect raised", 32'(need_indirect), 32'd1);
    chk("R8", "no ea on request", 32'(ea_valid), 32'd0);
    issue(mk(2'b00, 3'd0, 15'd5), 1'b0);
    chk("R10", "instr ignored while waiting", 32'(ea_valid), 32'd0);
    chk("R10", "still waiting", 32'(need_indirect), 32'd1);
    e = exp_ea(t, y);
    @(negedge clk);
    ind_word = mk(2'b11, t, y); ind_valid = 1'b1;
    @(negedge clk);
    ind_valid = 1'b0;
    chk("R8", "ea_valid after indirect", 32'(ea_valid), 32'd1);
    chk("R8", "ea from indirect word", 32'(e), 32'(ea));
    chk("R8", "need_indirect dropped", 32'(need_indirect), 32'd0);
  endtask

  task automatic t_spurious_ind();
    @(negedge clk);
    ind_word = mk(2'b00, 3'd0, 15'd9); ind_valid = 1'b1;
    @(negedge clk);
    ind_valid = 1'b0;
    chk("R10", "stray indirect ignored", 32'(ea_valid), 32'd0);
    chk("R10", "stray indirect no wait", 32'(need_indirect), 32'd0);
  endtask

  task automatic t_overlap();
    @(negedge clk);
    instr_word = mk(2'b00, 3'd1, 15'h0100); instr_valid = 1'b1;
    xr_load = 1'b1; load_value = 15'h0022;
    @(negedge clk);
    instr_valid = 1'b0; xr_load = 1'b0;
    chk("R9", "ea uses old register", 32'(ea), 32'h00EF);
    model_load(3'd1, 15'h0022);
    ea_is("R9", 3'd1, 15'h0100);
    chk("R9", "ea uses new register", 32'(ea), 32'h00DE);
  endtask

  task automatic t_leave();
    load(3'd3, 15'h0040, 1'b1);
    ea_is("R6", 3'd3, 15'h0050);
    chk("R6", "leave+load hits reg3 only", 32'(ea), 32'h0010);
    ea_is("R5", 3'd2, 15'h0050);
    chk("R5", "reg2 kept", 32'(ea), 32'h003F);
    ea_is("R5", 3'd5, 15'h0050);
    load(3'd7, 15'h0001, 1'b0);
    ea_is("R5", 3'd7, 15'h0000);
    chk("R5", "reg7 direct", 32'(ea), 32'h7FFF);
    t_indirect(3'd3, 15'h0041);
    @(negedge clk); leave_compat = 1'b1;
    @(negedge clk); leave_compat = 1'b0;
    ea_is("R6", 3'd6, 15'd9);
    chk("R6", "stays direct", 32'(ea), 32'd9);
  endtask

  task automatic t_reset_load();
    @(negedge clk);
    rst = 1'b1; xr_load = 1'b1; instr_word = mk(2'b00, 3'd3, '0); load_value = 15'd9;
    @(negedge clk);
    rst = 1'b0; xr_load = 1'b0;
    for (int i = 0; i < 8; i++) m_xr[i] = '0;
    m_compat = 1'b1;
    model_load(3'd3, 15'd9);
    ea_is("R6", 3'd7, 15'd20);
    chk("R6", "reset+load legacy", 32'(ea), 32'd11);
    ea_is("R2", 3'd4, 15'd20);
    chk("R2", "reg4 cleared", 32'(ea), 32'd20);
  endtask

  initial begin
    t_reset();
    t_compat();
    t_xctl();
    t_indirect(3'd4, 15'h0300);
    t_spurious_ind();
    t_overlap();
    t_leave();
    t_reset_load();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule